// File: doc/BRIEF.md
# Accelerator Descriptor-Space MMIO Responder

This block sits on the host-to-accelerator MMIO request port and answers accesses aimed at the accelerator's read-only descriptor space. The host raises a one-cycle valid strobe with a request. It then waits for the acknowledge before it sends the next request, so at most one request is ever in flight. The descriptor's first 64-bit word is built from four 16-bit parameters. These are the interrupts each process needs, the number of processes supported, the number of configuration records and the programming model required. A read of that word returns the four fields. Every other descriptor offset reads as zero.

Every valid request is acknowledged, including writes, accesses outside descriptor space and requests whose address parity is wrong, so the host never stalls. The acknowledge and the data word pass through two register stages. The returned data carries an odd-parity bit computed on the word currently on the output bus. A bad address parity is reported with an all-ones data word and a sticky error flag.

Top module: `cfg_mmio_responder`

## Requirements
- R1: While reset is high and after it is released with no request, rsp_ack is 0, rsp_data is 0, par_err is 0 and rsp_data_par is 1.
- R2: A request sampled at rising edge n produces rsp_ack high after edge n+1 for exactly one cycle, and rsp_ack stays 0 between edges n and n+1.
- R3: rsp_data_par always equals the inverted XOR reduction of rsp_data, so data and parity bit together have odd parity.
- R4: A 64-bit config read (req_wide=1) whose address has bits 23:1 all zero returns {ints_per_proc, num_procs, num_records, prog_model}, with ints_per_proc in bits 63:48 and prog_model in bits 15:0. Address bit 0 is ignored for such reads.
- R5: A 32-bit config read (req_wide=0) of word 0 returns one 32-bit half of that word copied into both halves of rsp_data. Address bit 0 set selects bits 31:0, and address bit 0 clear selects bits 63:32.
- R6: A config read whose address bits 23:1 are not all zero is acknowledged with zero data.
- R7: A config write (req_rd=0), or any access with req_cfg=0, is acknowledged with zero data and leaves later read results unchanged.
- R8: Address parity is good when the XOR of req_addr and req_addr_par is 1. On a bad parity the request is acknowledged with all-ones data, and par_err rises together with that acknowledge and stays high until reset.
- R9: When no request was sampled two edges earlier, rsp_ack is 0 and rsp_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_cfg | input | 1 | 1 = descriptor-space access |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wide | input | 1 | 1 = 64-bit, 0 = 32-bit access |
| req_addr | input | 24 | Request address |
| req_addr_par | input | 1 | Odd-parity bit over req_addr |
| rsp_ack | output | 1 | Acknowledge pulse |
| rsp_data | output | 64 | Read data |
| rsp_data_par | output | 1 | Odd-parity bit over rsp_data |
| par_err | output | 1 | Sticky address-parity error flag |

## Verification
The bench builds the responder with four distinct, non-zero descriptor fields (16'h00A5, 16'h0003, 16'h0C00, 16'h8010), so a swapped, shifted or dropped field appears as a miscompare. It sweeps every combination of config flag, direction and width over a set of addresses. The set covers both values of bit 0, the first undecoded word, and addresses with only the top bit set or all bits set, which reaches the decode boundary and the half select. Bad-parity requests come last, then a second reset, so the error flag's rise, its persistence and its clearing are all within reach.

// File: rtl/cfgmmio_pkg.sv
package cfgmmio_pkg;

    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 64;
    localparam int FIELD_W = 16;
    localparam int HALF_W  = DATA_W / 2;

    typedef struct packed {
        logic              valid;
        logic              cfg;
        logic              rd;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic              addr_par;
    } mmio_req_t;

    typedef struct packed {
        logic              ack;
        logic              perr;
        logic [DATA_W-1:0] data;
    } mmio_rsp_t;

    typedef struct packed {
        logic [FIELD_W-1:0] ints_per_proc;
        logic [FIELD_W-1:0] num_procs;
        logic [FIELD_W-1:0] num_records;
        logic [FIELD_W-1:0] prog_model;
    } desc_word0_t;

    localparam int RSP_W = $bits(mmio_rsp_t);

    // Odd parity over address plus parity bit: good when the XOR is 1.
    function automatic logic addr_par_good(input logic [ADDR_W-1:0] a, input logic p);
        return ^{a, p};
    endfunction

    // Pick one 32-bit half and repeat it on both halves of the bus.
    function automatic logic [DATA_W-1:0] narrow_read(input logic [DATA_W-1:0] w, input logic lo_half);
        logic [HALF_W-1:0] h;
        h = lo_half ? w[HALF_W-1:0] : w[DATA_W-1:HALF_W];
        return {h, h};
    endfunction

endpackage

// File: rtl/cfgmmio_decode.sv
module cfgmmio_decode
    import cfgmmio_pkg::*;
#(
    parameter logic [FIELD_W-1:0] INTS_PER_PROC = 16'h0000,
    parameter logic [FIELD_W-1:0] NUM_PROCS     = 16'h0001,
    parameter logic [FIELD_W-1:0] NUM_RECORDS   = 16'h0000,
    parameter logic [FIELD_W-1:0] PROG_MODEL    = 16'h8010
) (
    input  mmio_req_t req,
    output mmio_rsp_t rsp_next
);

    desc_word0_t word0;
    logic [DATA_W-1:0] sel_word;
    logic word_hit;

    assign word0.ints_per_proc = INTS_PER_PROC;
    assign word0.num_procs     = NUM_PROCS;
    assign word0.num_records   = NUM_RECORDS;
    assign word0.prog_model    = PROG_MODEL;

    assign word_hit = (req.addr[ADDR_W-1:1] == '0);
    assign sel_word = word_hit ? DATA_W'(word0) : '0;

    always_comb begin
        rsp_next = '0;
        if (req.valid) begin
            rsp_next.ack = 1'b1;
            if (!addr_par_good(req.addr, req.addr_par)) begin
                rsp_next.perr = 1'b1;
                rsp_next.data = '1;
            end else if (req.cfg && req.rd) begin
                rsp_next.data = req.wide ? sel_word : narrow_read(sel_word, req.addr[0]);
            end
        end
    end

endmodule

// File: rtl/cfgmmio_delay.sv
module cfgmmio_delay #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES+1];

    assign pipe[0] = d;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s+1] <= '0;
            else     pipe[s+1] <= pipe[s];
        end
    end

    assign q = pipe[STAGES];

endmodule

// File: rtl/cfg_mmio_responder.sv
module cfg_mmio_responder
    import cfgmmio_pkg::*;
#(
    parameter logic [15:0] INTS_PER_PROC = 16'h0000,
    parameter logic [15:0] NUM_PROCS     = 16'h0001,
    parameter logic [15:0] NUM_RECORDS   = 16'h0000,
    parameter logic [15:0] PROG_MODEL    = 16'h8010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_cfg,
    input  logic        req_rd,
    input  logic        req_wide,
    input  logic [23:0] req_addr,
    input  logic        req_addr_par,
    output logic        rsp_ack,
    output logic [63:0] rsp_data,
    output logic        rsp_data_par,
    output logic        par_err
);

    localparam int RSP_STAGES = 2;

    mmio_req_t req;
    mmio_rsp_t rsp_next;
    mmio_rsp_t rsp_out;
    logic      err_q;

    assign req.valid    = req_valid;
    assign req.cfg      = req_cfg;
    assign req.rd       = req_rd;
    assign req.wide     = req_wide;
    assign req.addr     = req_addr;
    assign req.addr_par = req_addr_par;

    cfgmmio_decode #(
        .INTS_PER_PROC (INTS_PER_PROC),
        .NUM_PROCS     (NUM_PROCS),
        .NUM_RECORDS   (NUM_RECORDS),
        .PROG_MODEL    (PROG_MODEL)
    ) i_decode (
        .req      (req),
        .rsp_next (rsp_next)
    );

    cfgmmio_delay #(
        .WIDTH  (RSP_W),
        .STAGES (RSP_STAGES)
    ) i_delay (
        .clk (clk),
        .rst (rst),
        .d   (rsp_next),
        .q   (rsp_out)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | (rsp_next.ack & rsp_next.perr);
    end

    // The sticky flag is presented together with the acknowledge.
    assign rsp_ack      = rsp_out.ack;
    assign rsp_data     = rsp_out.data;
    assign rsp_data_par = ~^rsp_out.data;
    assign par_err      = err_q & (par_err_seen_q | rsp_out.perr);

    logic par_err_seen_q;
    always_ff @(posedge clk) begin
        if (rst) par_err_seen_q <= 1'b0;
        else     par_err_seen_q <= par_err_seen_q | (rsp_out.ack & rsp_out.perr);
    end

    // R2: acknowledge two edges after the request is sampled
    a_r2_ack_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ##2 rsp_ack);

    // R9: no acknowledge means an idle, zero data bus
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rsp_ack |-> (rsp_data == '0));

    // R7: a good-parity write is answered with zero data
    a_r7_write_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_rd && addr_par_good(req_addr, req_addr_par)) |-> ##2 (rsp_data == '0));

    // R8: error flag never falls outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err);

    // R8: bad address parity gives all-ones data
    a_r8_bad_par_ones: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !addr_par_good(req_addr, req_addr_par)) |-> ##2 (rsp_ack && rsp_data == '1));

endmodule

// File: tb/test_cfg_mmio_responder.sv
module test_cfg_mmio_responder;

    localparam logic [15:0] T_INTS  = 16'h00A5;
    localparam logic [15:0] T_PROCS = 16'h0003;
    localparam logic [15:0] T_RECS  = 16'h0C00;
    localparam logic [15:0] T_MODEL = 16'h8010;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_cfg, req_rd, req_wide, req_addr_par;
    logic [23:0] req_addr;
    logic        rsp_ack, rsp_data_par, par_err;
    logic [63:0] rsp_data;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfg_mmio_responder #(
        .INTS_PER_PROC (T_INTS),
        .NUM_PROCS     (T_PROCS),
        .NUM_RECORDS   (T_RECS),
        .PROG_MODEL    (T_MODEL)
    ) i_cfg_mmio_responder (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_cfg      (req_cfg),
        .req_rd       (req_rd),
        .req_wide     (req_wide),
        .req_addr     (req_addr),
        .req_addr_par (req_addr_par),
        .rsp_ack      (rsp_ack),
        .rsp_data     (rsp_data),
        .rsp_data_par (rsp_data_par),
        .par_err      (par_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_data(input bit cfg, input bit rd, input bit wide,
                                                input logic [23:0] a, input bit bad);
        logic [63:0] w;
        if (bad) return {64{1'b1}};
        if (!(cfg && rd)) return 64'd0;
        if (a >= 24'd2) return 64'd0;
        w = (64'(T_INTS) << 48) + (64'(T_PROCS) << 32) + (64'(T_RECS) << 16) + 64'(T_MODEL);
        if (wide) return w;
        if (a[0]) return {w[31:0], w[31:0]};
        return {w[63:32], w[63:32]};
    endfunction

    task automatic send(input bit cfg, input bit rd, input bit wide, input logic [23:0] a, input bit bad);
        logic [63:0] exp;
        exp = expect_data(cfg, rd, wide, a, bad);
        @(negedge clk);
        req_valid    = 1'b1;
        req_cfg      = cfg;
        req_rd       = rd;
        req_wide     = wide;
        req_addr     = a;
        req_addr_par = ~(^a) ^ bad;
        @(negedge clk);
        req_valid = 1'b0;
        req_cfg = 1'b0; req_rd = 1'b0; req_wide = 1'b0; req_addr = '0; req_addr_par = 1'b0;
        check(rsp_ack == 1'b0, "R2 early ack", 64'(rsp_ack), 64'd0);
        @(negedge clk);
        check(rsp_ack == 1'b1, "R2 ack", 64'(rsp_ack), 64'd1);
        if (bad)
            check(rsp_data == exp, "R8 data", rsp_data, exp);
        else if (!(cfg && rd))
            check(rsp_data == exp, "R7 data", rsp_data, exp);
        else if (a >= 24'd2)
            check(rsp_data == exp, "R6 data", rsp_data, exp);
        else if (wide)
            check(rsp_data == exp, "R4 data", rsp_data, exp);
        else
            check(rsp_data == exp, "R5 data", rsp_data, exp);
        check(rsp_data_par == ~(^exp), "R3 parity", 64'(rsp_data_par), 64'(~(^exp)));
        @(negedge clk);
        check(rsp_ack == 1'b0 && rsp_data == 64'd0, "R9 idle", rsp_data, 64'd0);
        check(rsp_data_par == 1'b1, "R3 idle parity", 64'(rsp_data_par), 64'd1);
    endtask

    initial begin
        logic [23:0] addrs [9];
        addrs = '{24'h000000, 24'h000001, 24'h000002, 24'h000003, 24'h000010,
                  24'h800000, 24'h800001, 24'hFFFFFE, 24'hFFFFFF};
        rst = 1'b1;
        req_valid = 1'b0; req_cfg = 1'b0; req_rd = 1'b0; req_wide = 1'b0;
        req_addr = '0; req_addr_par = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_ack == 0 && rsp_data == 0 && par_err == 0 && rsp_data_par == 1,
              "R1 reset", rsp_data, 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_ack == 0 && rsp_data == 0 && par_err == 0 && rsp_data_par == 1,
              "R1 after release", rsp_data, 64'd0);

        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 2; r++)
                for (int w = 0; w < 2; w++)
                    for (int k = 0; k < 9; k++)
                        send(c[0], r[0], w[0], addrs[k], 1'b0);

        // R7: writes leave later reads unchanged
        send(1'b1, 1'b0, 1'b1, 24'h000000, 1'b0);
        send(1'b1, 1'b1, 1'b1, 24'h000000, 1'b0);
        check(par_err == 1'b0, "R8 no error yet", 64'(par_err), 64'd0);

        // R8: bad address parity
        send(1'b1, 1'b1, 1'b1, 24'h000000, 1'b1);
        check(par_err == 1'b1, "R8 flag set", 64'(par_err), 64'd1);
        send(1'b1, 1'b1, 1'b0, 24'h000001, 1'b0);
        check(par_err == 1'b1, "R8 flag sticky", 64'(par_err), 64'd1);
        send(1'b0, 1'b0, 1'b0, 24'h123456, 1'b1);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(par_err == 1'b0 && rsp_ack == 1'b0, "R1 reset clears flag", 64'(par_err), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule